// File: doc/BRIEF.md
# Peripheral Clock-Enable and Reset Sequencer

This block brings one peripheral at a time out of its stopped state in a safe order. It keeps the clock-stop bits and the reset bits for a parameterized number of peripherals. An enable request for a peripheral that has a reset line runs a timed, interlocked sequence: the reset is asserted, a setup interval passes, the clock is ungated, a settle interval passes, and then the reset is released. A peripheral without a reset line only has its clock ungated. A disable request stops the clock and leaves the reset bit alone. Both intervals are given in microseconds and turned into cycle counts from a clock-frequency parameter.

Each peripheral has its own clock-bit polarity, taken from an inversion mask. On most peripherals a set clock bit stops the clock. On an inverted peripheral a set bit lets the clock run. Every write to either register appears at the ports as a one-hot set or clear strobe. A peripheral counts as enabled only when its clock runs and it is not held in reset. Only one request is handled at a time. A request that arrives while a sequence is running is dropped.

Top module: `periph_enable_seq`

## Requirements
- R1: An enable request for a peripheral already reported enabled changes no register bit, raises no strobe, and gives done in the cycle after acceptance.
- R2: enabledVec[i] is 1 exactly when the clock of peripheral i runs and, if it has a reset line, its reset bit is 0. A peripheral with a running clock and a set reset bit reads 0.
- R3: For an enable of a peripheral with a reset line that is not enabled, the reset bit is 1 from the acceptance edge E0. The clock is ungated at edge E0+SETUP_CYC. The reset bit clears at edge E0+SETUP_CYC+SETTLE_CYC, and done is high in the cycle after that edge.
- R4: An enable of a peripheral without a reset line ungates its clock at the acceptance edge, never touches its reset bit, and gives done in the next cycle.
- R5: A disable request stops the clock at the acceptance edge, leaves every reset bit unchanged, and gives done in the next cycle. Outside of strobes, neither register changes.
- R6: busy is 1 from the cycle after an accepted sequenced enable up to and including the cycle before the reset-release edge, and 0 at all other times. done is never high together with busy.
- R7: reqValid is ignored while busy is 1. No bit changes and no done follows.
- R8: The clock bit of peripheral i means "running" when it equals INVERT_MASK[i]. After reset, every clock is stopped (clkBits = ~INVERT_MASK) and rstBits = HAS_RESET_MASK.
- R9: clkSetStb/clkClrStb and rstSetStb/rstClrStb are one-hot pulses in the cycle before the edge that updates the register. A set strobe makes the bit 1 and a clear strobe makes it 0. At most one clock strobe bit is high in a cycle.
- R10: SETUP_CYC = CLK_HZ*SETUP_US/1e6 and SETTLE_CYC = CLK_HZ*SETTLE_US/1e6, each at least 1, so that a sequenced enable lasts SETUP_CYC+SETTLE_CYC+1 cycles from acceptance to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when busy is 0 |
| reqEnable | input | 1 | 1 = enable, 0 = disable |
| reqIndex | input | IDX_W | Target peripheral |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| enabledVec | output | NUM_PERIPH | Enabled status per peripheral |
| clkBits | output | NUM_PERIPH | Clock-stop register image |
| rstBits | output | NUM_PERIPH | Reset register image (1 = held in reset) |
| clkSetStb | output | NUM_PERIPH | Clock register set strobe |
| clkClrStb | output | NUM_PERIPH | Clock register clear strobe |
| rstSetStb | output | NUM_PERIPH | Reset register set strobe |
| rstClrStb | output | NUM_PERIPH | Reset register clear strobe |

## Verification
The bench times a full sequenced enable edge by edge. A design that ungated the clock early or released the reset early would show a running clock in the wrong cycle, or done at the wrong latency. It enables a peripheral that is already on, and a peripheral with no reset line; a design that reran the sequence in either case would report done late. It also enables and disables the inverted-polarity peripheral, where a polarity slip would raise the wrong strobe and leave the bit wrong. It then injects a disable while a sequence is running, and disables a peripheral whose reset was released, which catches a design that acts on requests while busy or that re-asserts the reset on disable.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SETUP,
    SEQ_SETTLE
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;     // capture request index
    logic clkRun;      // ungate selected clock
    logic clkStop;     // stop selected clock
    logic rstAssert;   // put selected peripheral in reset
    logic rstRelease;  // take selected peripheral out of reset
    logic loadSetup;   // load setup interval
    logic loadSettle;  // load settle interval
    logic countDown;   // decrement interval counter
    logic finish;      // operation complete
  } seqStb_t;

endpackage

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
  import clkseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqEnable,
  input  logic    curEnabled,
  input  logic    curHasReset,
  input  logic    cntZero,
  output logic    seqActive,
  output seqStb_t stb
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign seqActive = (state != SEQ_IDLE);

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      SEQ_IDLE: begin
        if (reqValid) begin
          stb.loadReq = 1'b1;
          if (!reqEnable) begin
            stb.clkStop = 1'b1;
            stb.finish  = 1'b1;
          end else if (curEnabled) begin
            stb.finish = 1'b1;
          end else if (!curHasReset) begin
            stb.clkRun = 1'b1;
            stb.finish = 1'b1;
          end else begin
            stb.rstAssert = 1'b1;
            stb.loadSetup = 1'b1;
            stateNext     = SEQ_SETUP;
          end
        end
      end
      SEQ_SETUP: begin
        if (cntZero) begin
          stb.clkRun     = 1'b1;
          stb.loadSettle = 1'b1;
          stateNext      = SEQ_SETTLE;
        end else begin
          stb.countDown = 1'b1;
        end
      end
      SEQ_SETTLE: begin
        if (cntZero) begin
          stb.rstRelease = 1'b1;
          stb.finish     = 1'b1;
          stateNext      = SEQ_IDLE;
        end else begin
          stb.countDown = 1'b1;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

endmodule

// File: rtl/clkseq_dp.sv
module clkseq_dp
  import clkseq_pkg::*;
#(
  parameter int unsigned     NUM            = 8,
  parameter int unsigned     IDX_W          = 3,
  parameter int unsigned     CNT_W          = 8,
  parameter logic [NUM-1:0]  INVERT_MASK    = '0,
  parameter logic [NUM-1:0]  HAS_RESET_MASK = '1,
  parameter int unsigned     SETUP_CYC      = 4,
  parameter int unsigned     SETTLE_CYC     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStb_t          stb,
  input  logic             seqActive,
  input  logic [IDX_W-1:0] reqIndex,
  output logic             cntZero,
  output logic             curEnabled,
  output logic             curHasReset,
  output logic             done,
  output logic [NUM-1:0]   enabledVec,
  output logic [NUM-1:0]   clkBits,
  output logic [NUM-1:0]   rstBits,
  output logic [NUM-1:0]   clkSetStb,
  output logic [NUM-1:0]   clkClrStb,
  output logic [NUM-1:0]   rstSetStb,
  output logic [NUM-1:0]   rstClrStb
);

  logic [IDX_W-1:0] idxHeld;
  logic [IDX_W-1:0] curIdx;
  logic [NUM-1:0]   sel;
  logic [CNT_W-1:0] cnt;

  // During a sequence the captured index drives the selection
  assign curIdx = seqActive ? idxHeld : reqIndex;

  for (genvar i = 0; i < NUM; i++) begin : g_sel
    assign sel[i] = (curIdx == IDX_W'(i));
  end

  // Running value of a clock bit equals its inversion mask bit
  assign clkSetStb = sel & (({NUM{stb.clkRun}} & INVERT_MASK) |
                            ({NUM{stb.clkStop}} & ~INVERT_MASK));
  assign clkClrStb = sel & (({NUM{stb.clkRun}} & ~INVERT_MASK) |
                            ({NUM{stb.clkStop}} & INVERT_MASK));
  assign rstSetStb = sel & {NUM{stb.rstAssert}} & HAS_RESET_MASK;
  assign rstClrStb = sel & {NUM{stb.rstRelease}} & HAS_RESET_MASK;

  assign enabledVec  = ~(clkBits ^ INVERT_MASK) & ~(rstBits & HAS_RESET_MASK);
  assign curEnabled  = |(enabledVec & sel);
  assign curHasReset = |(HAS_RESET_MASK & sel);
  assign cntZero     = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkBits <= ~INVERT_MASK;
      rstBits <= HAS_RESET_MASK;
      idxHeld <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      clkBits <= (clkBits | clkSetStb) & ~clkClrStb;
      rstBits <= (rstBits | rstSetStb) & ~rstClrStb;
      done    <= stb.finish;
      if (stb.loadReq) idxHeld <= reqIndex;
      if (stb.loadSetup)       cnt <= CNT_W'(SETUP_CYC - 1);
      else if (stb.loadSettle) cnt <= CNT_W'(SETTLE_CYC - 1);
      else if (stb.countDown)  cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/periph_enable_seq.sv
module periph_enable_seq
  import clkseq_pkg::*;
#(
  parameter int unsigned            NUM_PERIPH     = 8,
  parameter int unsigned            CLK_HZ         = 100_000_000,
  parameter int unsigned            SETUP_US       = 100,
  parameter int unsigned            SETTLE_US      = 10_000,
  parameter logic [NUM_PERIPH-1:0]  INVERT_MASK    = 8'b0000_0100,
  parameter logic [NUM_PERIPH-1:0]  HAS_RESET_MASK = 8'b0111_1111,
  localparam int unsigned           IDX_W          = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqEnable,
  input  logic [IDX_W-1:0]      reqIndex,
  output logic                  busy,
  output logic                  done,
  output logic [NUM_PERIPH-1:0] enabledVec,
  output logic [NUM_PERIPH-1:0] clkBits,
  output logic [NUM_PERIPH-1:0] rstBits,
  output logic [NUM_PERIPH-1:0] clkSetStb,
  output logic [NUM_PERIPH-1:0] clkClrStb,
  output logic [NUM_PERIPH-1:0] rstSetStb,
  output logic [NUM_PERIPH-1:0] rstClrStb
);

  localparam longint unsigned SETUP_RAW  = (64'(CLK_HZ) * 64'(SETUP_US)) / 64'd1000000;
  localparam longint unsigned SETTLE_RAW = (64'(CLK_HZ) * 64'(SETTLE_US)) / 64'd1000000;
  localparam int unsigned SETUP_CYC  = (SETUP_RAW == 0) ? 1 : 32'(SETUP_RAW);
  localparam int unsigned SETTLE_CYC = (SETTLE_RAW == 0) ? 1 : 32'(SETTLE_RAW);
  localparam int unsigned MAX_CYC    = (SETUP_CYC > SETTLE_CYC) ? SETUP_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC) + 1;

  seqStb_t stb;
  logic    seqActive, cntZero, curEnabled, curHasReset;

  clkseq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqEnable   (reqEnable),
    .curEnabled  (curEnabled),
    .curHasReset (curHasReset),
    .cntZero     (cntZero),
    .seqActive   (seqActive),
    .stb         (stb)
  );

  clkseq_dp #(
    .NUM            (NUM_PERIPH),
    .IDX_W          (IDX_W),
    .CNT_W          (CNT_W),
    .INVERT_MASK    (INVERT_MASK),
    .HAS_RESET_MASK (HAS_RESET_MASK),
    .SETUP_CYC      (SETUP_CYC),
    .SETTLE_CYC     (SETTLE_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .seqActive   (seqActive),
    .reqIndex    (reqIndex),
    .cntZero     (cntZero),
    .curEnabled  (curEnabled),
    .curHasReset (curHasReset),
    .done        (done),
    .enabledVec  (enabledVec),
    .clkBits     (clkBits),
    .rstBits     (rstBits),
    .clkSetStb   (clkSetStb),
    .clkClrStb   (clkClrStb),
    .rstSetStb   (rstSetStb),
    .rstClrStb   (rstClrStb)
  );

  assign busy = seqActive;

endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk #(
  parameter int unsigned NUM = 8,
  parameter logic [NUM-1:0] INVERT_MASK    = '0,
  parameter logic [NUM-1:0] HAS_RESET_MASK = '1
) (
  input logic           clk,
  input logic           rstN,
  input logic           busy,
  input logic           done,
  input logic [NUM-1:0] enabledVec,
  input logic [NUM-1:0] clkBits,
  input logic [NUM-1:0] rstBits,
  input logic [NUM-1:0] clkSetStb,
  input logic [NUM-1:0] clkClrStb,
  input logic [NUM-1:0] rstSetStb,
  input logic [NUM-1:0] rstClrStb
);

  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_clk_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clkSetStb | clkClrStb) && ((clkSetStb & clkClrStb) == '0));

  p_clk_set_effect_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clkSetStb != '0) |=> ((clkBits & $past(clkSetStb)) == $past(clkSetStb)));

  p_rst_clr_effect_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rstClrStb != '0) |=> ((rstBits & $past(rstClrStb)) == '0));

  p_clk_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clkSetStb == '0 && clkClrStb == '0) |=> $stable(clkBits));

  p_rst_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rstSetStb == '0 && rstClrStb == '0) |=> $stable(rstBits));

  p_no_stop_while_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (((clkSetStb & ~INVERT_MASK) | (clkClrStb & INVERT_MASK)) == '0));

  p_enabled_needs_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((enabledVec & (clkBits ^ INVERT_MASK)) == '0) &&
    ((enabledVec & rstBits & HAS_RESET_MASK) == '0));

endmodule

bind periph_enable_seq clkseq_chk #(
  .NUM            (NUM_PERIPH),
  .INVERT_MASK    (INVERT_MASK),
  .HAS_RESET_MASK (HAS_RESET_MASK)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .enabledVec (enabledVec),
  .clkBits    (clkBits),
  .rstBits    (rstBits),
  .clkSetStb  (clkSetStb),
  .clkClrStb  (clkClrStb),
  .rstSetStb  (rstSetStb),
  .rstClrStb  (rstClrStb)
);

// File: tb/test_periph_enable_seq.sv
module test_periph_enable_seq;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int SETUP      = 3;   // 1 MHz * 3 us
  localparam int SETTLE     = 5;   // 1 MHz * 5 us
  localparam int LFULL      = SETUP + SETTLE + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqEnable = 1'b0;
  logic [1:0] reqIndex = '0;
  logic busy, done;
  logic [N-1:0] enabledVec, clkBits, rstBits, clkSetStb, clkClrStb, rstSetStb, rstClrStb;

  periph_enable_seq #(
    .NUM_PERIPH     (N),
    .CLK_HZ         (1_000_000),
    .SETUP_US       (SETUP),
    .SETTLE_US      (SETTLE),
    .INVERT_MASK    (4'b0100),
    .HAS_RESET_MASK (4'b0111)
  ) i_periph_enable_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnable(reqEnable),
    .reqIndex(reqIndex), .busy(busy), .done(done), .enabledVec(enabledVec),
    .clkBits(clkBits), .rstBits(rstBits), .clkSetStb(clkSetStb),
    .clkClrStb(clkClrStb), .rstSetStb(rstSetStb), .rstClrStb(rstClrStb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int        cyc;
    logic [3:0] en, ck, rs;
    string     tag;
  } exp_t;

  exp_t expQ[$];
  int   cyc = 0;
  int   nCompared = 0;
  int   nMismatch = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic checkEq(input string what, input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // Monitor: pop one expectation per done pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        checkEq("R6 unexpected done pulse", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        checkEq({e.tag, " R10 done cycle"}, e.cyc, e.cyc);
        if (cyc != e.cyc) checkEq({e.tag, " R10 done latency"}, cyc, e.cyc);
        checkEq({e.tag, " enabledVec"}, e.en == enabledVec ? e.en : enabledVec, e.en);
        checkEq({e.tag, " clkBits"}, clkBits, e.ck);
        checkEq({e.tag, " rstBits"}, rstBits, e.rs);
      end
    end
  end

  // Driver: issue one request, push its expectation, check accept strobes (R9)
  task automatic request(input logic en, input logic [1:0] idx, input int lat,
                         input logic [3:0] eEn, input logic [3:0] eCk, input logic [3:0] eRs,
                         input logic [3:0] eSet, input logic [3:0] eClr, input string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1; reqEnable = en; reqIndex = idx;
    e.cyc = cyc + lat; e.en = eEn; e.ck = eCk; e.rs = eRs; e.tag = tag;
    expQ.push_back(e);
    #1;
    checkEq({tag, " R9 clkSetStb at accept"}, clkSetStb, eSet);
    checkEq({tag, " R9 clkClrStb at accept"}, clkClrStb, eClr);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R8 reset state
    checkEq("R8 reset clkBits", clkBits, 4'b1011);
    checkEq("R8 reset rstBits", rstBits, 4'b0111);
    checkEq("R2 reset enabledVec", enabledVec, 4'b0000);
    checkEq("R6 reset busy", busy, 0);
    checkEq("R6 reset done", done, 0);

    // A: full sequenced enable of peripheral 0 (R3)
    request(1, 0, LFULL, 4'b0001, 4'b1010, 4'b0110, 4'b0000, 4'b0000, "R3 enable p0");
    checkEq("R6 busy after accept", busy, 1);
    checkEq("R3 reset held after accept", rstBits[0], 1);
    checkEq("R3 clock still stopped after accept", clkBits[0], 1);
    waitCycles(SETUP);
    checkEq("R3 clock ungated after setup", clkBits[0], 0);
    checkEq("R3 reset still held after setup", rstBits[0], 1);
    checkEq("R2 running but in reset reads disabled", enabledVec[0], 0);
    waitCycles(SETTLE - 1);
    checkEq("R6 busy before release", busy, 1);
    checkEq("R3 reset held before release", rstBits[0], 1);
    waitCycles(1);
    checkEq("R6 busy low at done", busy, 0);
    waitCycles(1);
    checkEq("R6 done is a pulse", done, 0);

    // B: already enabled (R1)
    request(1, 0, 1, 4'b0001, 4'b1010, 4'b0110, 4'b0000, 4'b0000, "R1 re-enable p0");
    checkEq("R1 no busy", busy, 0);
    waitCycles(2);

    // C: no reset line (R4)
    request(1, 3, 1, 4'b1001, 4'b0010, 4'b0110, 4'b0000, 4'b1000, "R4 enable p3");
    checkEq("R4 no busy", busy, 0);
    waitCycles(2);

    // D: inverted polarity with reset (R8), disable injected while busy (R7)
    request(1, 2, LFULL, 4'b1101, 4'b0110, 4'b0010, 4'b0000, 4'b0000, "R8 enable p2");
    reqValid = 1'b1; reqEnable = 1'b0; reqIndex = 2'd0;
    @(negedge clk);
    reqValid = 1'b0;
    checkEq("R7 ignored disable keeps p0 clock", clkBits[0], 0);
    waitCycles(SETUP - 1);
    checkEq("R8 inverted clock bit set when ungated", clkBits[2], 1);
    waitCycles(SETTLE + 2);
    checkEq("R7 p0 still enabled after ignored request", enabledVec[0], 1);

    // E: disable p0 (R5)
    request(0, 0, 1, 4'b1100, 4'b0111, 4'b0010, 4'b0001, 4'b0000, "R5 disable p0");
    waitCycles(2);

    // F: disable inverted p2 (R8)
    request(0, 2, 1, 4'b1000, 4'b0011, 4'b0010, 4'b0000, 4'b0100, "R8 disable p2");
    waitCycles(2);

    // G: enable p1, then disable keeps reset released (R5)
    request(1, 1, LFULL, 4'b1010, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R10 enable p1");
    waitCycles(LFULL + 1);
    request(0, 1, 1, 4'b1000, 4'b0011, 4'b0000, 4'b0010, 4'b0000, "R5 disable p1");
    waitCycles(2);
    checkEq("R5 reset untouched by disable", rstBits[1], 0);

    // I: re-enable p1 from stopped, out-of-reset state reruns sequence (R3)
    request(1, 1, LFULL, 4'b1010, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R3 re-enable p1");
    checkEq("R3 reset re-asserted", rstBits[1], 1);
    waitCycles(LFULL + 2);

    checkEq("R6 all expected done pulses seen", expQ.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

endmodule